// File: doc/BRIEF.md
# Receive Descriptor Ring Sequencer

This block moves bytes from a receive channel into memory buffers. A circular table of receive descriptors in a word-wide descriptor memory says where each buffer is. When a byte arrives and no buffer is open, the sequencer reads the status word of the current descriptor. If the descriptor is marked empty, it fetches the buffer address and stores bytes there one after another. The buffer is closed for one of three reasons:

- the configured maximum length is reached,
- a byte flagged as end-of-frame is stored,
- the channel flags an error.

On closing, the sequencer writes the byte count into the descriptor's length word and then rewrites its status word. After that it moves to the next descriptor, or back to the first one when the wrap flag is set.

Software hands a descriptor to the block by setting its empty flag. If data arrives while the current descriptor is still owned by software, the block pulses a busy error and drops the byte. It stays on that descriptor and checks it again on every later byte. A continuous option per descriptor keeps the empty flag set after closing, so that the descriptor is reused on the next pass around the ring.

Each descriptor is three consecutive words at `DTAB_BASE + 3*index`:

| Offset | Word |
|---|---|
| +0 | status |
| +1 | length |
| +2 | buffer address |

The status word has these fields:

| Bit | Field |
|---|---|
| 15 | empty |
| 13 | wrap |
| 11 | last-in-frame |
| 9 | continuous |
| 1 | error |

The channel presents at most one byte every 8 clock cycles, the rate of a serial line running at one bit per clock or slower. The descriptor memory returns read data one cycle after `dm_re`.

Top module: `rx_ring_seq`

## Requirements
- R1: While `chan_en` is low the block makes no descriptor or buffer write and raises no busy error. After `chan_en` rises, the first buffer opened uses descriptor 0.
- R2: The n-th byte stored into a buffer (counting from 0) is written to `buf_addr` = buffer address word + n.
- R3: When the number of bytes stored reaches `max_len` (a value of 0 acts as 1), the buffer is closed with last-in-frame (bit 11) clear.
- R4: A byte with `rx_eof` set is stored, and the buffer is then closed with last-in-frame (bit 11) set.
- R5: A byte with `rx_err` set is not stored. The open buffer (or a newly opened one) is closed with error (bit 1) set and last-in-frame clear.
- R6: On closing, the length word (+1) receives the number of bytes stored. In the next cycle the status word (+0) is written with wrap (bit 13) and continuous (bit 9) unchanged.
- R7: After a descriptor is closed, the next one used is index 0 if its wrap bit (13) was set, or if it is the last table entry. Otherwise it is the next index.
- R8: If the current descriptor has empty (bit 15) clear when a byte arrives, `busy_err` pulses for one cycle. The byte is discarded, nothing is written, and the same descriptor is checked again on every later byte.
- R9: A descriptor closed with continuous (bit 9) set keeps empty (bit 15) at 1. Otherwise empty is cleared to 0.
- R10: Lowering `chan_en` while a buffer is open abandons it without writing the length or status word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chan_en | input | 1 | Receive channel enable |
| rx_valid | input | 1 | A received byte is present this cycle |
| rx_data | input | 8 | Received byte |
| rx_eof | input | 1 | The byte ends a frame |
| rx_err | input | 1 | The channel reports an error; the byte is discarded |
| max_len | input | LEN_W | Maximum bytes per buffer, common to all descriptors |
| dm_re | output | 1 | Descriptor memory read strobe |
| dm_we | output | 1 | Descriptor memory write strobe |
| dm_addr | output | AW | Descriptor memory word address |
| dm_wdata | output | DW | Descriptor memory write data |
| dm_rdata | input | DW | Descriptor memory read data, one cycle after dm_re |
| buf_we | output | 1 | Data buffer byte write strobe |
| buf_addr | output | BAW | Data buffer byte address |
| buf_wdata | output | 8 | Data buffer byte |
| busy_err | output | 1 | One-cycle pulse: byte arrived for a descriptor not marked empty |

## Verification
The ring is driven with five kinds of traffic:

- a short end-of-frame packet, which exercises the store-and-close path;
- a frame longer than `max_len`, which separates a length close from a frame-end close and shows the spill into the next descriptor;
- an error byte after a good one, which shows that an error byte is not stored;
- repeated bytes against a descriptor software still owns, which shows that the block neither advances nor writes;
- a continuous-mode descriptor, which separates kept empty flags from cleared ones.

Two more patterns work the enable. Toggling it between frames shows the restart at entry 0, and dropping it in mid-buffer shows that an abandoned buffer gets no write-back.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
   localparam int ST_EMPTY = 15;
   localparam int ST_WRAP  = 13;
   localparam int ST_LAST  = 11;
   localparam int ST_CONT  = 9;
   localparam int ST_ERR   = 1;
   localparam int WORDS_PER_DESC = 3;

   typedef enum logic [1:0] {
      WS_STAT = 2'd0,
      WS_LEN  = 2'd1,
      WS_ADDR = 2'd2
   } wsel_t;

   typedef enum logic [3:0] {
      S_IDLE, S_WAIT, S_FS, S_FC, S_FA, S_FB, S_OPEN, S_CL, S_CS
   } seq_state_t;
endpackage

// File: rtl/rxr_ring_idx.sv
module rxr_ring_idx #(
   parameter int NDESC     = 4,
   parameter int AW        = 8,
   parameter int DTAB_BASE = 0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          adv,
   input  logic          wrap_req,
   output logic [AW-1:0] desc_base
);
   import rxr_pkg::*;
   localparam int IDX_W = (NDESC > 1) ? $clog2(NDESC) : 1;

   logic [IDX_W-1:0] idx;
   logic [IDX_W-1:0] idx_inc;

   generate
      if (NDESC < 2) begin : g_bad_n
         $error("NDESC must be at least 2");
      end
      if (DTAB_BASE + WORDS_PER_DESC * NDESC > (1 << AW)) begin : g_bad_aw
         $error("descriptor table does not fit the address width");
      end
      if (NDESC == (1 << IDX_W)) begin : g_pow2
         assign idx_inc = idx + IDX_W'(1);
      end else begin : g_cmp
         assign idx_inc = (idx == IDX_W'(NDESC - 1)) ? '0 : idx + IDX_W'(1);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                idx <= '0;
      else if (clr)              idx <= '0;
      else if (adv && wrap_req)  idx <= '0;
      else if (adv)              idx <= idx_inc;
   end

   assign desc_base = AW'(DTAB_BASE + WORDS_PER_DESC * int'(idx));

   AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      int'(idx) < NDESC);                                      // R7
   AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && wrap_req && !clr) |=> (desc_base == AW'(DTAB_BASE))); // R7
endmodule

// File: rtl/rxr_fill_ctr.sv
module rxr_fill_ctr #(
   parameter int LEN_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             inc,
   input  logic [LEN_W-1:0] max_len,
   output logic [LEN_W-1:0] count,
   output logic             last_slot
);
   logic [LEN_W:0] eff_max;
   logic [LEN_W:0] count_p1;

   generate
      if (LEN_W < 1) begin : g_bad_len
         $error("LEN_W must be positive");
      end
   endgenerate

   assign eff_max   = (max_len == '0) ? (LEN_W+1)'(1) : {1'b0, max_len};
   assign count_p1  = {1'b0, count} + (LEN_W+1)'(1);
   assign last_slot = (count_p1 >= eff_max);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    count <= '0;
      else if (clr)  count <= '0;
      else if (inc)  count <= count + LEN_W'(1);
   end

   AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && !clr) |-> ({1'b0, count} < eff_max));           // R3
endmodule

// File: rtl/rxr_ctrl.sv
module rxr_ctrl #(
   parameter int AW    = 8,
   parameter int DW    = 16,
   parameter int BAW   = 16,
   parameter int LEN_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             chan_en,
   input  logic             rx_valid,
   input  logic [7:0]       rx_data,
   input  logic             rx_eof,
   input  logic             rx_err,
   input  logic [AW-1:0]    desc_base,
   input  logic [LEN_W-1:0] count,
   input  logic             last_slot,
   output logic             cnt_clr,
   output logic             cnt_inc,
   output logic             idx_clr,
   output logic             idx_adv,
   output logic             wrap_req,
   output logic             dm_re,
   output logic             dm_we,
   output logic [AW-1:0]    dm_addr,
   output logic [DW-1:0]    dm_wdata,
   input  logic [DW-1:0]    dm_rdata,
   output logic             buf_we,
   output logic [BAW-1:0]   buf_addr,
   output logic [7:0]       buf_wdata,
   output logic             busy_err
);
   import rxr_pkg::*;

   generate
      if (DW < 16) begin : g_bad_dw
         $error("DW must hold the 16-bit status layout");
      end
      if (BAW > DW || LEN_W > DW) begin : g_bad_w
         $error("BAW and LEN_W must not exceed DW");
      end
   endgenerate

   seq_state_t     state;
   wsel_t          wsel;
   logic [7:0]     pend_data;
   logic           pend_eof, pend_err;
   logic [DW-1:0]  stat_q;
   logic [BAW-1:0] base_q;
   logic           close_eof, close_err;

   logic           take_valid, take_eof, take_err, take_close;
   logic [7:0]     take_data;
   logic [BAW-1:0] take_base;
   logic [DW-1:0]  stat_new;

   always_comb begin
      take_valid = (state == S_FB) || (state == S_OPEN && rx_valid);
      take_data  = (state == S_FB) ? pend_data : rx_data;
      take_eof   = (state == S_FB) ? pend_eof  : rx_eof;
      take_err   = (state == S_FB) ? pend_err  : rx_err;
      take_base  = (state == S_FB) ? dm_rdata[BAW-1:0] : base_q;
      take_close = take_valid && (take_err || take_eof || last_slot);

      stat_new = stat_q;
      if (!stat_q[ST_CONT]) stat_new[ST_EMPTY] = 1'b0;
      stat_new[ST_LAST] = close_eof;
      stat_new[ST_ERR]  = close_err;

      wsel = WS_STAT;
      dm_re = 1'b0;
      dm_we = 1'b0;
      dm_wdata = '0;
      case (state)
         S_FS: begin dm_re = chan_en; wsel = WS_STAT; end
         S_FA: begin dm_re = chan_en; wsel = WS_ADDR; end
         S_CL: begin dm_we = chan_en; wsel = WS_LEN;  dm_wdata = DW'(count); end
         S_CS: begin dm_we = chan_en; wsel = WS_STAT; dm_wdata = stat_new; end
         default: ;
      endcase
      dm_addr = desc_base + AW'(wsel);

      buf_we    = chan_en && take_valid && !take_err;
      buf_addr  = take_base + BAW'(count);
      buf_wdata = take_data;
      cnt_inc   = buf_we;
      cnt_clr   = !chan_en || (state == S_CS);
      idx_clr   = !chan_en;
      idx_adv   = chan_en && (state == S_CS);
      wrap_req  = stat_q[ST_WRAP];
      busy_err  = chan_en && (state == S_FC) && !dm_rdata[ST_EMPTY];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= S_IDLE;
         pend_data <= '0;
         pend_eof  <= 1'b0;
         pend_err  <= 1'b0;
         stat_q    <= '0;
         base_q    <= '0;
         close_eof <= 1'b0;
         close_err <= 1'b0;
      end else if (!chan_en) begin
         state <= S_IDLE;
      end else begin
         case (state)
            S_IDLE: state <= S_WAIT;
            S_WAIT: if (rx_valid) begin
               pend_data <= rx_data;
               pend_eof  <= rx_eof;
               pend_err  <= rx_err;
               state     <= S_FS;
            end
            S_FS: state <= S_FC;
            S_FC: if (!dm_rdata[ST_EMPTY]) begin
               state <= S_WAIT;
            end else begin
               stat_q <= dm_rdata;
               state  <= S_FA;
            end
            S_FA: state <= S_FB;
            S_FB, S_OPEN: begin
               if (state == S_FB) base_q <= dm_rdata[BAW-1:0];
               if (take_close) begin
                  close_eof <= take_eof && !take_err;
                  close_err <= take_err;
                  state     <= S_CL;
               end else begin
                  state <= S_OPEN;
               end
            end
            S_CL: state <= S_CS;
            S_CS: state <= S_WAIT;
            default: state <= S_IDLE;
         endcase
      end
   end

   AST_LEN_THEN_STAT: assert property (@(posedge clk) disable iff (!rst_n)
      (dm_we && wsel == WS_STAT) |-> $past(dm_we && wsel == WS_LEN));   // R6
   AST_BUSY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      busy_err |-> (!dm_we && !buf_we));                               // R8
   AST_BUSY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      busy_err |=> !busy_err);                                         // R8
   AST_PACED_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && chan_en) |-> (state == S_WAIT || state == S_OPEN)); // R2
   AST_ERR_NOT_STORED: assert property (@(posedge clk) disable iff (!rst_n)
      (state == S_OPEN && rx_valid && rx_err) |-> !buf_we);            // R5
endmodule

// File: rtl/rx_ring_seq.sv
module rx_ring_seq #(
   parameter int NDESC     = 4,
   parameter int AW        = 8,
   parameter int DTAB_BASE = 0,
   parameter int DW        = 16,
   parameter int BAW       = 16,
   parameter int LEN_W     = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             chan_en,
   input  logic             rx_valid,
   input  logic [7:0]       rx_data,
   input  logic             rx_eof,
   input  logic             rx_err,
   input  logic [LEN_W-1:0] max_len,
   output logic             dm_re,
   output logic             dm_we,
   output logic [AW-1:0]    dm_addr,
   output logic [DW-1:0]    dm_wdata,
   input  logic [DW-1:0]    dm_rdata,
   output logic             buf_we,
   output logic [BAW-1:0]   buf_addr,
   output logic [7:0]       buf_wdata,
   output logic             busy_err
);
   logic [AW-1:0]    desc_base;
   logic [LEN_W-1:0] count;
   logic             last_slot, cnt_clr, cnt_inc, idx_clr, idx_adv, wrap_req;

   rxr_ring_idx #(.NDESC(NDESC), .AW(AW), .DTAB_BASE(DTAB_BASE)) u_ring (
      .clk(clk), .rst_n(rst_n), .clr(idx_clr), .adv(idx_adv),
      .wrap_req(wrap_req), .desc_base(desc_base));

   rxr_fill_ctr #(.LEN_W(LEN_W)) u_fill (
      .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .inc(cnt_inc),
      .max_len(max_len), .count(count), .last_slot(last_slot));

   rxr_ctrl #(.AW(AW), .DW(DW), .BAW(BAW), .LEN_W(LEN_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .rx_valid(rx_valid),
      .rx_data(rx_data), .rx_eof(rx_eof), .rx_err(rx_err),
      .desc_base(desc_base), .count(count), .last_slot(last_slot),
      .cnt_clr(cnt_clr), .cnt_inc(cnt_inc), .idx_clr(idx_clr),
      .idx_adv(idx_adv), .wrap_req(wrap_req), .dm_re(dm_re), .dm_we(dm_we),
      .dm_addr(dm_addr), .dm_wdata(dm_wdata), .dm_rdata(dm_rdata),
      .buf_we(buf_we), .buf_addr(buf_addr), .buf_wdata(buf_wdata),
      .busy_err(busy_err));

   AST_QUIET_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!chan_en) |-> (!dm_we && !buf_we && !busy_err));   // R1
endmodule

// File: tb/rx_ring_seq_tb.sv
`timescale 1ns/1ps
module rx_ring_seq_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        chan_en = 1'b0;
   logic        rx_valid = 1'b0;
   logic [7:0]  rx_data = '0;
   logic        rx_eof = 1'b0;
   logic        rx_err = 1'b0;
   logic [15:0] max_len = 16'd8;
   logic        dm_re, dm_we, buf_we, busy_err;
   logic [7:0]  dm_addr;
   logic [15:0] dm_wdata;
   logic [15:0] dm_rdata = '0;
   logic [15:0] buf_addr;
   logic [7:0]  buf_wdata;

   logic [15:0] dmem [0:255];
   logic [7:0]  bmem [0:255];
   int n_chk = 0, n_fail = 0;
   int busy_cnt = 0, bwr_cnt = 0, dwr_cnt = 0, stat_wr = 0, order_bad = 0;
   logic        prev_we = 1'b0;
   logic [7:0]  prev_addr = '0;

   always #2.5 clk = ~clk;

   rx_ring_seq u_dut (
      .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .rx_valid(rx_valid),
      .rx_data(rx_data), .rx_eof(rx_eof), .rx_err(rx_err), .max_len(max_len),
      .dm_re(dm_re), .dm_we(dm_we), .dm_addr(dm_addr), .dm_wdata(dm_wdata),
      .dm_rdata(dm_rdata), .buf_we(buf_we), .buf_addr(buf_addr),
      .buf_wdata(buf_wdata), .busy_err(busy_err));

   always @(posedge clk) begin
      if (dm_re) dm_rdata <= dmem[dm_addr];
      if (dm_we) begin
         dmem[dm_addr] <= dm_wdata;
         dwr_cnt <= dwr_cnt + 1;
         if (dm_addr % 3 == 0) begin
            stat_wr <= stat_wr + 1;
            if (!(prev_we && prev_addr == dm_addr + 8'd1)) order_bad <= order_bad + 1;
         end
      end
      prev_we   <= dm_we;
      prev_addr <= dm_addr;
      if (buf_we) begin
         bmem[buf_addr[7:0]] <= buf_wdata;
         bwr_cnt <= bwr_cnt + 1;
      end
      if (busy_err) busy_cnt <= busy_cnt + 1;
   end

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic set_desc(input int i, input logic [15:0] st, input logic [15:0] ad);
      dmem[i*3]   = st;
      dmem[i*3+1] = 16'h0000;
      dmem[i*3+2] = ad;
   endtask

   task automatic send(input logic [7:0] d, input logic e, input logic er);
      @(negedge clk);
      rx_valid = 1'b1; rx_data = d; rx_eof = e; rx_err = er;
      @(negedge clk);
      rx_valid = 1'b0; rx_eof = 1'b0; rx_err = 1'b0;
      repeat (6) @(negedge clk);
   endtask

   task automatic t_reset;
      @(negedge clk);
      chk("R1 reset dm_we", {15'd0, dm_we}, 16'd0);
      chk("R1 reset buf_we", {15'd0, buf_we}, 16'd0);
      chk("R1 reset busy_err", {15'd0, busy_err}, 16'd0);
   endtask

   task automatic t_eof_frame;
      max_len = 16'd8;
      send(8'hA1, 0, 0); send(8'hA2, 0, 0); send(8'hA3, 1, 0);
      repeat (4) @(negedge clk);
      chk("R2 byte0", {8'd0, bmem[0]}, 16'h00A1);
      chk("R2 byte2", {8'd0, bmem[2]}, 16'h00A3);
      chk("R6 length", dmem[1], 16'd3);
      chk("R4 status L set E cleared", dmem[0], 16'h0800);
   endtask

   task automatic t_full;
      max_len = 16'd4;
      for (int i = 0; i < 4; i++) send(8'hB0 + 8'(i), 0, 0);
      send(8'hC0, 1, 0);
      repeat (4) @(negedge clk);
      max_len = 16'd8;
      chk("R3 full length", dmem[4], 16'd4);
      chk("R3 full status L clear", dmem[3], 16'h0000);
      chk("R2 full last byte", {8'd0, bmem[8'h43]}, 16'h00B3);
      chk("R7 spill to next desc", {8'd0, bmem[8'h80]}, 16'h00C0);
      chk("R4 spill status", dmem[6], 16'h0800);
      chk("R6 spill length", dmem[7], 16'd1);
   endtask

   task automatic t_err;
      int w0;
      send(8'hD1, 0, 0);
      w0 = bwr_cnt;
      send(8'hEE, 0, 1);
      repeat (4) @(negedge clk);
      chk("R5 error byte not stored", 16'(bwr_cnt - w0), 16'd0);
      chk("R5 error length", dmem[10], 16'd1);
      chk("R5 error status W kept", dmem[9], 16'h2002);
   endtask

   task automatic t_busy;
      int b0, w0, d0;
      b0 = busy_cnt; w0 = bwr_cnt; d0 = dwr_cnt;
      send(8'h11, 1, 0);
      chk("R8 busy pulse", 16'(busy_cnt - b0), 16'd1);
      send(8'h12, 1, 0);
      chk("R8 busy rechecked", 16'(busy_cnt - b0), 16'd2);
      chk("R8 no buffer write", 16'(bwr_cnt - w0), 16'd0);
      chk("R8 no desc write", 16'(dwr_cnt - d0), 16'd0);
      chk("R7 wrap returned to desc0", dmem[0], 16'h0800);
      set_desc(0, 16'h8200, 16'h0000);
      send(8'h13, 1, 0);
      repeat (4) @(negedge clk);
      chk("R8 resumes same desc", {8'd0, bmem[0]}, 16'h0013);
      chk("R9 continuous keeps E", dmem[0], 16'h8A00);
   endtask

   task automatic t_restart;
      int w0, d0, b0;
      @(negedge clk) chan_en = 1'b0;
      w0 = bwr_cnt; d0 = dwr_cnt; b0 = busy_cnt;
      send(8'h99, 1, 0);
      chk("R1 disabled no writes", 16'((bwr_cnt - w0) + (dwr_cnt - d0) + (busy_cnt - b0)), 16'd0);
      set_desc(0, 16'h8000, 16'h0000);
      @(negedge clk) chan_en = 1'b1;
      repeat (3) @(negedge clk);
      send(8'h5A, 1, 0);
      repeat (4) @(negedge clk);
      chk("R1 restart at desc0", {8'd0, bmem[0]}, 16'h005A);
      chk("R1 restart status", dmem[0], 16'h0800);
   endtask

   task automatic t_abandon;
      set_desc(1, 16'h8000, 16'h0040);
      send(8'h77, 0, 0);
      chk("R2 abandon byte stored", {8'd0, bmem[8'h40]}, 16'h0077);
      @(negedge clk) chan_en = 1'b0;
      repeat (8) @(negedge clk);
      chk("R10 no status write", dmem[3], 16'h8000);
      chk("R10 no length write", dmem[4], 16'h0000);
      chan_en = 1'b1;
      repeat (3) @(negedge clk);
   endtask

   initial begin
      for (int i = 0; i < 256; i++) begin dmem[i] = '0; bmem[i] = '0; end
      set_desc(0, 16'h8000, 16'h0000);
      set_desc(1, 16'h8000, 16'h0040);
      set_desc(2, 16'h8000, 16'h0080);
      set_desc(3, 16'hA000, 16'h00C0);
      repeat (3) @(negedge clk);
      t_reset;
      rst_n = 1'b1;
      @(negedge clk) chan_en = 1'b1;
      repeat (3) @(negedge clk);
      t_eof_frame;
      t_full;
      t_err;
      t_busy;
      t_restart;
      t_abandon;
      chk("R6 length before status order", 16'(order_bad), 16'd0);
      chk("R6 status writes seen", {15'd0, stat_wr > 0}, 16'd1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule